// File: doc/BRIEF.md
# Multiprocessor-Capable Asynchronous Serial Port

This block is a full-duplex asynchronous serial port. One 8-bit control/status register sets it up and reports its state. It sends and receives LSB-first frames: a low start bit, eight data bits, an optional ninth bit, and a high stop bit. A frame-format field selects the 8-bit or the 9-bit layout. In the 9-bit layout the transmitter sends the ninth bit from a register bit, and the receiver stores the ninth bit it receives in another register bit. An address-filter bit turns the receiver into an address listener for multidrop links. With the filter on, a 9-bit frame whose ninth bit is 0 is dropped without any visible effect.

Bit timing comes from an external `baud_tick` strobe, taken as 16 samples per bit. When `speed_x2` is low, only every second strobe is used. When it is high, every strobe is used, which doubles the bit rate. The receiver passes its line through a synchronizer. It finds a falling edge and decides each bit by a majority vote of samples 7, 8 and 9 within the bit. If the start bit reads high at mid-bit, the receiver drops it as a false start. Completion flags for transmit and receive are set by hardware and cleared only by software writes. The interrupt output is high while either flag is set.

Control register layout: bit 0 RXON (receiver enable), bit 1 ADDRFLT (address filter), bits 3:2 FMT (00 off, 01 8-bit, 10 and 11 9-bit), bit 4 TXB9 (ninth bit to send), bit 5 RXB9 (ninth bit received), bit 6 TXDONE, bit 7 RXDONE. A register write loads all eight bits.

Top module: `mp_serial_port`

## Requirements
- R1: After synchronous reset, the control register reads 0x00, `txd` is 1, `irq` is 0 and `rx_rdata` is 0.
- R2: A `tx_we` strobe sends start 0, then `tx_wdata` LSB first, then (when FMT is 10 or 11) the TXB9 bit, then stop 1. Each bit lasts 16 used baud ticks.
- R3: With FMT 00, `tx_we` sends nothing and sets no TXDONE, and the receiver accepts no frame even when RXON is set.
- R4: TXDONE (bit 6) sets when the stop bit of a frame has been sent, and stays set until a register write clears it. A `tx_we` strobe while a frame is still being sent is ignored.
- R5: The receiver accepts frames only while RXON (bit 0) is 1. An accepted frame loads its data into `rx_rdata` and sets RXDONE (bit 7). With RXON 0, a frame leaves both unchanged.
- R6: With FMT 10 or 11, the received ninth bit is stored in RXB9 (bit 5).
- R7: With FMT 01 and ADDRFLT 0, RXB9 takes the value of the received stop bit, 0 or 1.
- R8: With FMT 10 or 11 and ADDRFLT (bit 1) set, a frame whose ninth bit is 0 leaves RXDONE, RXB9 and `rx_rdata` unchanged. A frame whose ninth bit is 1 is accepted.
- R9: A low pulse on `rxd` that has ended before sample 7 of the start bit is rejected with no effect, and the next real frame is still received.
- R10: With `speed_x2` 0, a bit lasts 32 `baud_tick` strobes. With `speed_x2` 1, it lasts 16.
- R11: `irq` equals TXDONE OR RXDONE. If a hardware flag set and a register write fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling strobe, one cycle wide |
| speed_x2 | input | 1 | 1: use every strobe (double rate) |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write value |
| reg_rdata | output | 8 | Control register contents |
| tx_we | input | 1 | Transmit data write strobe, starts a frame |
| tx_wdata | input | DATA_W | Byte to transmit |
| rx_rdata | output | DATA_W | Last accepted received byte |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idle high |
| irq | output | 1 | Interrupt, high while a done flag is set |

## Verification
Two sources can change a done flag in the same cycle: the receiver setting RXDONE at the end of a stop bit, and a software write that loads the register with that flag at 0. The bench provokes this by writing the register with RXDONE 0 on every cycle around the end of the stop bit. It stops writing on the first cycle `irq` is seen high. The colliding write is therefore the last one, so RXDONE must still read 1 afterwards. If software won the collision, `irq` would never rise and the check reports it.

// File: rtl/mp_serial_pkg.sv
package mp_serial_pkg;

  typedef enum logic [1:0] {
    FMT_OFF   = 2'b00,
    FMT_EIGHT = 2'b01,
    FMT_NINE0 = 2'b10,
    FMT_NINE1 = 2'b11
  } frame_fmt_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_NINTH,
    RX_STOP
  } rx_state_e;

  localparam int CTL_W      = 8;
  localparam int CTL_RXON   = 0;
  localparam int CTL_FILT   = 1;
  localparam int CTL_FMT_LO = 2;
  localparam int CTL_FMT_HI = 3;
  localparam int CTL_TXB9   = 4;
  localparam int CTL_RXB9   = 5;
  localparam int CTL_TXDONE = 6;
  localparam int CTL_RXDONE = 7;

endpackage

// File: rtl/mp_tick_gen.sv
module mp_tick_gen (
  input  logic clk,
  input  logic rst,
  input  logic baud_tick,
  input  logic speed_x2,
  output logic smp_tick
);
  logic half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q   <= 1'b0;
      smp_tick <= 1'b0;
    end else begin
      smp_tick <= baud_tick & (speed_x2 | half_q);
      if (baud_tick) half_q <= ~half_q;
    end
  end
endmodule

// File: rtl/mp_tx.sv
module mp_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  logic              bit9,
  input  logic              nine,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(OVS);
  localparam int BITS_W  = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   ovs_q;
  logic [BITS_W-1:0]  left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      ovs_q  <= '0;
      left_q <= '0;
      busy   <= 1'b0;
      txd    <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        txd <= 1'b1;
        if (start) begin
          busy   <= 1'b1;
          ovs_q  <= '0;
          txd    <= 1'b0;
          sh_q   <= nine ? {1'b1, bit9, data, 1'b0} : {1'b1, 1'b1, data, 1'b0};
          left_q <= nine ? BITS_W'(FRAME_W) : BITS_W'(FRAME_W - 1);
        end
      end else begin
        txd <= sh_q[0];
        if (tick) begin
          if (ovs_q == CNT_W'(OVS - 1)) begin
            ovs_q  <= '0;
            sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
            left_q <= left_q - 1'b1;
            if (left_q == BITS_W'(1)) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end else begin
            ovs_q <= ovs_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mp_rx.sv
module mp_rx
  import mp_serial_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd_s,
  input  logic              enable,
  input  logic              nine,
  input  logic              filt,
  output logic [DATA_W-1:0] data_q,
  output logic              accept_q,
  output logic              b9_we_q,
  output logic              b9_val_q
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int MID   = OVS / 2;

  rx_state_e         st_q;
  logic [CNT_W-1:0]  ovs_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              s_lo_q, s_mid_q, bit_q, ninth_q;
  logic              maj;

  assign maj = (s_lo_q & s_mid_q) | (s_lo_q & rxd_s) | (s_mid_q & rxd_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= RX_IDLE;
      ovs_q    <= '0;
      idx_q    <= '0;
      sh_q     <= '0;
      s_lo_q   <= 1'b1;
      s_mid_q  <= 1'b1;
      bit_q    <= 1'b1;
      ninth_q  <= 1'b0;
      data_q   <= '0;
      accept_q <= 1'b0;
      b9_we_q  <= 1'b0;
      b9_val_q <= 1'b0;
    end else begin
      accept_q <= 1'b0;
      b9_we_q  <= 1'b0;
      if (!enable) begin
        st_q <= RX_IDLE;
      end else if (tick) begin
        if (st_q == RX_IDLE) begin
          if (!rxd_s) begin
            st_q  <= RX_START;
            ovs_q <= CNT_W'(1);
          end
        end else begin
          ovs_q <= ovs_q + 1'b1;
          if (ovs_q == CNT_W'(MID - 1)) s_lo_q  <= rxd_s;
          if (ovs_q == CNT_W'(MID))     s_mid_q <= rxd_s;
          if (ovs_q == CNT_W'(MID + 1)) begin
            bit_q <= maj;
            if (st_q == RX_START && maj) begin
              st_q <= RX_IDLE;
            end else if (st_q == RX_STOP) begin
              st_q <= RX_IDLE;
              if (!(nine && filt && !ninth_q)) begin
                accept_q <= 1'b1;
                data_q   <= sh_q;
                if (nine) begin
                  b9_we_q  <= 1'b1;
                  b9_val_q <= ninth_q;
                end else if (!filt) begin
                  b9_we_q  <= 1'b1;
                  b9_val_q <= maj;
                end
              end
            end
          end
          if (ovs_q == CNT_W'(OVS - 1)) begin
            ovs_q <= '0;
            case (st_q)
              RX_START: begin
                st_q  <= RX_DATA;
                idx_q <= '0;
              end
              RX_DATA: begin
                sh_q  <= {bit_q, sh_q[DATA_W-1:1]};
                idx_q <= idx_q + 1'b1;
                if (idx_q == IDX_W'(DATA_W - 1)) st_q <= nine ? RX_NINTH : RX_STOP;
              end
              RX_NINTH: begin
                ninth_q <= bit_q;
                st_q    <= RX_STOP;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/mp_ctl_reg.sv
module mp_ctl_reg
  import mp_serial_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [CTL_W-1:0] reg_wdata,
  input  logic             tx_set,
  input  logic             rx_set,
  input  logic             b9_we,
  input  logic             b9_val,
  output logic [CTL_W-1:0] ctrl_q,
  output logic             irq_q
);
  logic [CTL_W-1:0] nxt;

  always_comb begin
    nxt = ctrl_q;
    if (reg_we) nxt = reg_wdata;
    if (b9_we)  nxt[CTL_RXB9] = b9_val;
    if (tx_set) nxt[CTL_TXDONE] = 1'b1;
    if (rx_set) nxt[CTL_RXDONE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= nxt;
      irq_q  <= nxt[CTL_TXDONE] | nxt[CTL_RXDONE];
    end
  end
endmodule

// File: rtl/mp_serial_port.sv
module mp_serial_port
  import mp_serial_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              speed_x2,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              tx_we,
  input  logic [DATA_W-1:0] tx_wdata,
  output logic [DATA_W-1:0] rx_rdata,
  input  logic              rxd,
  output logic              txd,
  output logic              irq
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [CTL_W-1:0]       ctrl_q;
  logic                   smp_tick, fmt_on, nine, tx_busy, tx_done;
  logic                   rx_accept, b9_we, b9_val;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end

  assign fmt_on = (ctrl_q[CTL_FMT_HI:CTL_FMT_LO] != FMT_OFF);
  assign nine   = ctrl_q[CTL_FMT_HI];

  mp_tick_gen u_tick (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .speed_x2(speed_x2), .smp_tick(smp_tick)
  );

  mp_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(smp_tick),
    .start(tx_we & fmt_on & ~tx_busy), .data(tx_wdata),
    .bit9(ctrl_q[CTL_TXB9]), .nine(nine),
    .txd(txd), .busy(tx_busy), .done(tx_done)
  );

  mp_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(smp_tick), .rxd_s(sync_q[SYNC_STAGES-1]),
    .enable(ctrl_q[CTL_RXON] & fmt_on), .nine(nine), .filt(ctrl_q[CTL_FILT]),
    .data_q(rx_rdata), .accept_q(rx_accept), .b9_we_q(b9_we), .b9_val_q(b9_val)
  );

  mp_ctl_reg u_ctl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .tx_set(tx_done), .rx_set(rx_accept), .b9_we(b9_we), .b9_val(b9_val),
    .ctrl_q(ctrl_q), .irq_q(irq)
  );

  assign reg_rdata = ctrl_q;
endmodule

// File: rtl/mp_serial_port_chk.sv
module mp_serial_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [7:0]        reg_rdata,
  input logic              txd,
  input logic              irq,
  input logic              rx_accept,
  input logic [DATA_W-1:0] rx_rdata
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (reg_rdata == 8'h00 && txd && !irq));

  a_r11_irq_follows_flags: assert property (@(posedge clk) disable iff (rst)
    irq == (reg_rdata[6] | reg_rdata[7]));

  a_r4_txdone_sticky: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[6] && !reg_we) |=> reg_rdata[6]);

  a_r5_no_accept_when_off: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata[0] |=> !rx_accept);

  a_r5_rxdone_has_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_rdata[7]) |-> ($past(rx_accept) || $past(reg_we)));

  a_r8_buffer_only_on_accept: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_rdata) |-> rx_accept);
endmodule

bind mp_serial_port mp_serial_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_rdata(reg_rdata), .txd(txd),
  .irq(irq), .rx_accept(rx_accept), .rx_rdata(rx_rdata)
);

// File: tb/mp_serial_port_tb.sv
`timescale 1ns/1ps
module mp_serial_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       speed_x2 = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tx_we = 1'b0;
  logic [7:0] tx_wdata = 8'h00;
  logic [7:0] rx_rdata;
  logic       rxd = 1'b1;
  logic       txd;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int bitclk = 64;
  int tick_cnt = 0;
  bit done_run = 0;

  logic [8:0] got;
  logic [7:0] d, prev;
  bit         b, oks, stp, hit;
  int         lows;

  always #2.5 clk = ~clk;

  mp_serial_port u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .speed_x2(speed_x2),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_rdata(rx_rdata),
    .rxd(rxd), .txd(txd), .irq(irq)
  );

  always @(negedge clk) begin
    tick_cnt  = (tick_cnt + 1) % 4;
    baud_tick = (tick_cnt == 0);
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] frame_val(input logic [7:0] v, input bit n, input bit nb);
    return n ? {nb, v} : {1'b0, v};
  endfunction

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wr_tx(input logic [7:0] v);
    @(negedge clk); tx_we = 1'b1; tx_wdata = v;
    @(negedge clk); tx_we = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [7:0] v, input bit n, input bit nb, input bit sv);
    @(negedge clk); rxd = 1'b0; wait_clk(bitclk);
    for (int i = 0; i < 8; i++) begin rxd = v[i]; wait_clk(bitclk); end
    if (n) begin rxd = nb; wait_clk(bitclk); end
    rxd = sv; wait_clk(bitclk);
    rxd = 1'b1;
  endtask

  task automatic grab_tx(input bit n, output logic [8:0] g, output bit ok_start, output bit stop_v);
    int w = 0;
    while (txd !== 1'b0 && w < 4 * bitclk) begin @(negedge clk); w++; end
    wait_clk(bitclk / 2);
    ok_start = (txd === 1'b0);
    g = '0;
    for (int i = 0; i < (n ? 9 : 8); i++) begin wait_clk(bitclk); g[i] = txd; end
    wait_clk(bitclk);
    stop_v = txd;
  endtask

  task automatic count_lows(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (txd == 1'b0) c++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_run) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    wait_clk(5);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(reg_rdata == 8'h00, "R1 ctl", reg_rdata, 0);
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(rx_rdata == 8'h00, "R1 rx_rdata", rx_rdata, 0);

    // R2 / R4 / R11: 8-bit transmit
    for (int k = 0; k < 4; k++) begin
      d = 8'($urandom);
      if (k == 0) d = 8'h00;
      if (k == 1) d = 8'hFF;
      wr_ctl(8'h04);
      wr_tx(d);
      grab_tx(1'b0, got, oks, stp);
      check(oks, "R2 start bit", oks, 1);
      check(got == frame_val(d, 1'b0, 1'b0), "R2 tx data", got, frame_val(d, 1'b0, 1'b0));
      check(stp == 1'b1, "R2 stop bit", stp, 1);
      wait_clk(bitclk / 2 + 8);
      check(reg_rdata[6] == 1'b1, "R4 txdone set", reg_rdata[6], 1);
      check(irq == 1'b1, "R11 irq on txdone", irq, 1);
      wait_clk(bitclk);
      check(reg_rdata[6] == 1'b1, "R4 txdone held", reg_rdata[6], 1);
      wr_ctl(8'h04);
      @(negedge clk);
      check(reg_rdata[6] == 1'b0, "R4 txdone cleared", reg_rdata[6], 0);
      check(irq == 1'b0, "R11 irq cleared", irq, 0);
    end

    // R4: write while busy is ignored
    wr_tx(8'hA5);
    wait_clk(3 * bitclk);
    wr_tx(8'h3C);
    wait_clk(8 * bitclk);
    check(reg_rdata[6] == 1'b1, "R4 first frame done", reg_rdata[6], 1);
    count_lows(12 * bitclk, lows);
    check(lows == 0, "R4 busy write ignored", lows, 0);
    wr_ctl(8'h04);

    // R2: 9-bit transmit
    for (int k = 0; k < 4; k++) begin
      d = 8'($urandom);
      b = 1'($urandom);
      wr_ctl(8'h08 | (b ? 8'h10 : 8'h00));
      wr_tx(d);
      grab_tx(1'b1, got, oks, stp);
      check(oks && stp, "R2 nine framing", {oks, stp}, 3);
      check(got == frame_val(d, 1'b1, b), "R2 nine tx data", got, frame_val(d, 1'b1, b));
      wait_clk(bitclk);
    end

    // R3: format off
    wr_ctl(8'h01);
    wr_tx(8'h55);
    count_lows(12 * bitclk, lows);
    check(lows == 0, "R3 no tx when off", lows, 0);
    check(reg_rdata[6] == 1'b0, "R3 no txdone when off", reg_rdata[6], 0);
    drive_frame(8'h5A, 1'b0, 1'b0, 1'b1);
    wait_clk(8);
    check(reg_rdata[7] == 1'b0, "R3 no rx when off", reg_rdata[7], 0);

    // R5 / R7: 8-bit receive
    wr_ctl(8'h05);
    for (int k = 0; k < 4; k++) begin
      d = 8'($urandom);
      drive_frame(d, 1'b0, 1'b0, 1'b1);
      wait_clk(8);
      check(rx_rdata == d, "R5 rx data", rx_rdata, d);
      check(reg_rdata[7] == 1'b1, "R5 rxdone", reg_rdata[7], 1);
      check(reg_rdata[5] == 1'b1, "R7 stop into rxb9", reg_rdata[5], 1);
      check(irq == 1'b1, "R11 irq on rxdone", irq, 1);
      wr_ctl(8'h05);
    end
    d = 8'h96;
    drive_frame(d, 1'b0, 1'b0, 1'b0);
    wait_clk(8);
    check(reg_rdata[5] == 1'b0, "R7 low stop into rxb9", reg_rdata[5], 0);
    check(rx_rdata == d, "R5 rx data low stop", rx_rdata, d);
    wait_clk(3 * bitclk);
    wr_ctl(8'h05);

    // R5: receiver disabled
    wr_ctl(8'h04);
    prev = rx_rdata;
    drive_frame(~prev, 1'b0, 1'b0, 1'b1);
    wait_clk(8);
    check(reg_rdata[7] == 1'b0, "R5 no rxdone when disabled", reg_rdata[7], 0);
    check(rx_rdata == prev, "R5 buffer kept when disabled", rx_rdata, prev);

    // R6: 9-bit receive
    for (int k = 0; k < 4; k++) begin
      d = 8'($urandom);
      b = (k % 2 == 0);
      wr_ctl(b ? 8'h09 : 8'h29);
      drive_frame(d, 1'b1, b, 1'b1);
      wait_clk(8);
      check(rx_rdata == d, "R6 nine rx data", rx_rdata, d);
      check(reg_rdata[5] == b, "R6 ninth bit", reg_rdata[5], b);
      check(reg_rdata[7] == 1'b1, "R6 rxdone", reg_rdata[7], 1);
    end

    // R8: address filter
    wr_ctl(8'h2B);
    prev = rx_rdata;
    drive_frame(~prev, 1'b1, 1'b0, 1'b1);
    wait_clk(8);
    check(reg_rdata[7] == 1'b0, "R8 filtered no rxdone", reg_rdata[7], 0);
    check(reg_rdata[5] == 1'b1, "R8 filtered rxb9 kept", reg_rdata[5], 1);
    check(rx_rdata == prev, "R8 filtered buffer kept", rx_rdata, prev);
    wr_ctl(8'h0B);
    d = ~prev;
    drive_frame(d, 1'b1, 1'b1, 1'b1);
    wait_clk(8);
    check(reg_rdata[7] == 1'b1, "R8 address accepted", reg_rdata[7], 1);
    check(reg_rdata[5] == 1'b1, "R8 address rxb9", reg_rdata[5], 1);
    check(rx_rdata == d, "R8 address data", rx_rdata, d);

    // R9: false start
    wr_ctl(8'h05);
    prev = rx_rdata;
    @(negedge clk); rxd = 1'b0;
    wait_clk(16);
    rxd = 1'b1;
    wait_clk(12 * bitclk);
    check(reg_rdata[7] == 1'b0, "R9 glitch rejected", reg_rdata[7], 0);
    check(rx_rdata == prev, "R9 buffer kept", rx_rdata, prev);
    d = 8'hC3;
    drive_frame(d, 1'b0, 1'b0, 1'b1);
    wait_clk(8);
    check(rx_rdata == d && reg_rdata[7], "R9 recovery frame", rx_rdata, d);

    // R10: half speed
    speed_x2 = 1'b0;
    bitclk = 128;
    wr_ctl(8'h04);
    d = 8'($urandom);
    wr_tx(d);
    grab_tx(1'b0, got, oks, stp);
    check(oks && stp, "R10 slow framing", {oks, stp}, 3);
    check(got == frame_val(d, 1'b0, 1'b0), "R10 slow tx data", got, frame_val(d, 1'b0, 1'b0));
    wait_clk(bitclk);
    wr_ctl(8'h05);
    d = 8'($urandom);
    drive_frame(d, 1'b0, 1'b0, 1'b1);
    wait_clk(16);
    check(rx_rdata == d && reg_rdata[7], "R10 slow rx data", rx_rdata, d);
    speed_x2 = 1'b1;
    bitclk = 64;
    wait_clk(bitclk);

    // R11: hardware set against software clear in the same cycle
    wr_ctl(8'h05);
    d = 8'h6E;
    hit = 1'b0;
    fork
      drive_frame(d, 1'b0, 1'b0, 1'b1);
      begin
        wait_clk(9 * bitclk);
        for (int i = 0; i < 3 * bitclk && !hit; i++) begin
          @(negedge clk);
          if (irq) begin reg_we = 1'b0; hit = 1'b1; end
          else begin reg_we = 1'b1; reg_wdata = 8'h05; end
        end
        reg_we = 1'b0;
      end
    join
    wait_clk(4);
    check(hit, "R11 irq rose under writes", hit, 1);
    check(reg_rdata[7] == 1'b1, "R11 hw set wins", reg_rdata[7], 1);
    check(rx_rdata == d, "R11 data", rx_rdata, d);

    done_run = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule